// File: doc/BRIEF.md
# Reseeding Scan Pattern Source

This block is a built-in self-test stimulus source for scan testing. A 16-bit linear feedback shift register steps once per clock and its low stage is sent out as a serial scan bit. The register is loaded with a seed at the start of each run and again after a fixed number of patterns. The seeds are fixed constants in the logic, so no seed memory or external tester is needed. Between loads the register runs freely and produces pseudo-random bits.

A bit-modifier stage sits on the serial output. It inverts single bits at fixed positions so that chosen deterministic values reach the scan chain. Each position is named by a bit counter (place within the 16-bit pattern) and a global pattern index. The block marks the last bit of every pattern and gives a one-cycle done pulse once all patterns have been sent. A start pulse from idle begins a run and the run then continues on its own.

Top module: `rsg_pattern_gen`

## Requirements
- R1: While `rst` is high, and after it is released until a start, `scan_valid`, `pat_last` and `done` are low.
- R2: A `start` sampled high while idle loads seed 0. The first serial bit of the run is valid in the next cycle.
- R3: The register shifts right once per valid bit. The serial output before inversion is stage 0, and the new stage 15 is stage 0 ^ stage 2 ^ stage 3 ^ stage 5, which gives the polynomial x^16+x^14+x^13+x^11+1.
- R4: A pattern is 16 consecutive valid bits, numbered 0 to 15 in output order. `pat_last` is high exactly on bit 15.
- R5: After 64 patterns of a seed, the register is loaded with the next seed instead of being stepped, at the pattern boundary. The seeds in order are 16'hACE1, 16'h1D87, 16'h5A3C, 16'hF00D.
- R6: A serial bit is inverted only when its (bit number, global pattern index 0..255) pair is one of (3,0), (15,5), (15,63), (0,64), (7,127), (12,128), (15,255).
- R7: After bit 15 of pattern 255, `scan_valid` drops. `done` is high for exactly the next cycle.
- R8: A `start` pulse during a run has no effect on the stream.
- R9: The register is never all-zero while bits are valid.
- R10: A start after `done` produces the same bit stream again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| scan_bit | output | 1 | Serial scan stimulus bit |
| scan_valid | output | 1 | `scan_bit` carries a pattern bit |
| pat_last | output | 1 | Current bit is the last of its pattern |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
Two functions can fall in the same cycle, and both cases are set up on purpose. The first is the reseed load and the bit inversion: the inversion table has entries on bit 15 of pattern 63 and on bit 0 of pattern 64, which frame the load of seed 1. The second is the end of the run and an inversion on its last bit: the table has an entry on bit 15 of pattern 255, the cycle that triggers the done pulse. A scoreboard model derives the feedback from the polynomial exponents and compares every serial bit and boundary strobe. A wrong load order, a missing inversion or a late done therefore shows up as a mismatch at a named pattern and bit.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int LFSR_W = 16;

  // One right shift; feedback enters the top stage.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[0] ^ s[2] ^ s[3] ^ s[5];
    return {fb, s[LFSR_W-1:1]};
  endfunction

  // Hard-wired seeds, all nonzero.
  function automatic logic [LFSR_W-1:0] seed_word(input int idx);
    case (idx)
      0:       return 16'hACE1;
      1:       return 16'h1D87;
      2:       return 16'h5A3C;
      3:       return 16'hF00D;
      default: return 16'h0001 + 16'(idx);
    endcase
  endfunction

  // Inversion table: (bit number within pattern, global pattern index).
  function automatic logic flip_hit(input int bpos, input int pat);
    return (bpos == 3  && pat == 0)   ||
           (bpos == 15 && pat == 5)   ||
           (bpos == 15 && pat == 63)  ||
           (bpos == 0  && pat == 64)  ||
           (bpos == 7  && pat == 127) ||
           (bpos == 12 && pat == 128) ||
           (bpos == 15 && pat == 255);
  endfunction
endpackage

// File: rtl/rsg_seq_ctrl.sv
module rsg_seq_ctrl
  import rsg_pkg::*;
#(
  parameter int PAT_W         = 16,
  parameter int PATS_PER_SEED = 64,
  parameter int NUM_SEEDS     = 4,
  localparam int BIT_CW  = $clog2(PAT_W),
  localparam int SEG_CW  = $clog2(PATS_PER_SEED),
  localparam int PAT_CW  = $clog2(PATS_PER_SEED * NUM_SEEDS),
  localparam int SEED_CW = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              running,
  output logic [BIT_CW-1:0] bit_cnt,
  output logic [PAT_CW-1:0] pat_idx,
  output logic              load_now,
  output logic              step_now,
  output logic [LFSR_W-1:0] load_word,
  output logic              last_bit,
  output logic              done_q
);
  logic [SEG_CW-1:0]  seg_pat;
  logic [SEED_CW-1:0] seed_idx;
  logic               seg_end;
  logic               fin;

  assign last_bit  = running && (bit_cnt == BIT_CW'(PAT_W - 1));
  assign seg_end   = last_bit && (seg_pat == SEG_CW'(PATS_PER_SEED - 1));
  assign fin       = seg_end && (seed_idx == SEED_CW'(NUM_SEEDS - 1));
  assign load_now  = (!running && start) || (seg_end && !fin);
  assign step_now  = running && !seg_end;
  assign load_word = running ? seed_word(int'(seed_idx) + 1) : seed_word(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      bit_cnt  <= '0;
      pat_idx  <= '0;
      seg_pat  <= '0;
      seed_idx <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (!running) begin
        if (start) begin
          running  <= 1'b1;
          bit_cnt  <= '0;
          pat_idx  <= '0;
          seg_pat  <= '0;
          seed_idx <= '0;
        end
      end else begin
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit) begin
          pat_idx <= pat_idx + 1'b1;
          seg_pat <= seg_end ? '0 : seg_pat + 1'b1;
        end
        if (seg_end && !fin) seed_idx <= seed_idx + 1'b1;
        if (fin) running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsg_lfsr.sv
module rsg_lfsr
  import rsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LFSR_W-1:0] load_val,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)       state <= seed_word(0);
    else if (load) state <= load_val;
    else if (step) state <= lfsr_step(state);
  end
endmodule

// File: rtl/rsg_bit_mod.sv
module rsg_bit_mod
  import rsg_pkg::*;
#(
  parameter int BIT_CW = 4,
  parameter int PAT_CW = 8
) (
  input  logic              raw_bit,
  input  logic              valid,
  input  logic [BIT_CW-1:0] bit_cnt,
  input  logic [PAT_CW-1:0] pat_idx,
  output logic              flip_now,
  output logic              out_bit
);
  assign flip_now = valid && flip_hit(int'(bit_cnt), int'(pat_idx));
  assign out_bit  = raw_bit ^ flip_now;
endmodule

// File: rtl/rsg_pattern_gen.sv
module rsg_pattern_gen
  import rsg_pkg::*;
#(
  parameter int PAT_W         = 16,
  parameter int PATS_PER_SEED = 64,
  parameter int NUM_SEEDS     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic scan_bit,
  output logic scan_valid,
  output logic pat_last,
  output logic done
);
  localparam int BIT_CW = $clog2(PAT_W);
  localparam int PAT_CW = $clog2(PATS_PER_SEED * NUM_SEEDS);

  logic              running;
  logic [BIT_CW-1:0] bit_cnt;
  logic [PAT_CW-1:0] pat_idx;
  logic              load_now;
  logic              step_now;
  logic [LFSR_W-1:0] load_word;
  logic [LFSR_W-1:0] lfsr_q;
  logic              last_bit;
  logic              done_q;
  logic              flip_now;

  rsg_seq_ctrl #(
    .PAT_W(PAT_W), .PATS_PER_SEED(PATS_PER_SEED), .NUM_SEEDS(NUM_SEEDS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .running(running),
    .bit_cnt(bit_cnt), .pat_idx(pat_idx), .load_now(load_now),
    .step_now(step_now), .load_word(load_word), .last_bit(last_bit),
    .done_q(done_q)
  );

  rsg_lfsr u_lfsr (
    .clk(clk), .rst(rst), .load(load_now), .load_val(load_word),
    .step(step_now), .state(lfsr_q)
  );

  rsg_bit_mod #(.BIT_CW(BIT_CW), .PAT_CW(PAT_CW)) u_mod (
    .raw_bit(lfsr_q[0]), .valid(running), .bit_cnt(bit_cnt),
    .pat_idx(pat_idx), .flip_now(flip_now), .out_bit(scan_bit)
  );

  assign scan_valid = running;
  assign pat_last   = last_bit;
  assign done       = done_q;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker
  import rsg_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              scan_valid,
  input logic              pat_last,
  input logic              done,
  input logic              load_now,
  input logic              step_now,
  input logic              flip_now,
  input logic [LFSR_W-1:0] lfsr_state
);
  localparam int PW = $clog2(PAT_W);
  logic [PW-1:0] chk_pos;

  always_ff @(posedge clk) begin
    if (rst || !scan_valid)                  chk_pos <= '0;
    else if (chk_pos == PW'(PAT_W - 1))      chk_pos <= '0;
    else                                     chk_pos <= chk_pos + 1'b1;
  end

  AST_NO_ZERO_STATE: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> lfsr_state != '0); // R9
  AST_PAT_FRAME: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> (pat_last == (chk_pos == PW'(PAT_W - 1)))); // R4
  AST_RESEED_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (load_now && scan_valid) |-> pat_last); // R5
  AST_STEP_RULE: assert property (@(posedge clk) disable iff (rst)
    (scan_valid && step_now) |=> lfsr_state == lfsr_step($past(lfsr_state))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(pat_last) && !scan_valid)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (scan_valid && start && !pat_last) |=> scan_valid); // R8
  AST_START_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!scan_valid && start) |=> scan_valid); // R2
  AST_FLIP_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    flip_now |-> scan_valid); // R6
endmodule

bind rsg_pattern_gen rsg_checker #(.PAT_W(PAT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .scan_valid(scan_valid),
  .pat_last(pat_last), .done(done), .load_now(load_now),
  .step_now(step_now), .flip_now(flip_now), .lfsr_state(lfsr_q)
);

// File: tb/rsg_pattern_gen_bench.sv
`timescale 1ns/1ps
module rsg_pattern_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic scan_bit, scan_valid, pat_last, done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic       b;
    logic       last;
    logic [7:0] gp;
    logic [3:0] bp;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  rsg_pattern_gen u_rsg_pattern_gen (
    .clk(clk), .rst(rst), .start(start), .scan_bit(scan_bit),
    .scan_valid(scan_valid), .pat_last(pat_last), .done(done)
  );

  // Reference model written from the requirements.
  function automatic logic [15:0] ref_seed(input int k);
    logic [15:0] tbl [4] = '{16'hACE1, 16'h1D87, 16'h5A3C, 16'hF00D};
    return tbl[k];
  endfunction

  function automatic logic [15:0] ref_step(input logic [15:0] s);
    int ex [4] = '{16, 14, 13, 11};
    logic fb = 1'b0;
    foreach (ex[i]) fb ^= s[16 - ex[i]];
    return (s >> 1) | (16'(fb) << 15);
  endfunction

  function automatic logic ref_flip(input int b, input int p);
    int fb_b [7] = '{3, 15, 15, 0, 7, 12, 15};
    int fb_p [7] = '{0, 5, 63, 64, 127, 128, 255};
    foreach (fb_b[i]) if (fb_b[i] == b && fb_p[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // Driver: push the expected stream of one full run.
  task automatic push_run();
    logic [15:0] s;
    for (int seg = 0; seg < 4; seg++) begin
      s = ref_seed(seg);
      for (int p = 0; p < 64; p++) begin
        for (int b = 0; b < 16; b++) begin
          item_t it;
          it.gp   = 8'(seg * 64 + p);
          it.bp   = 4'(b);
          it.b    = s[0] ^ ref_flip(b, seg * 64 + p);
          it.last = (b == 15);
          exp_q.push_back(it);
          s = ref_step(s);
        end
      end
    end
  endtask

  // Monitor: pop and compare every valid bit.
  always @(negedge clk) begin
    if (!rst && scan_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 extra bit", 1, 0);
      end else begin
        item_t it;
        string tag;
        it = exp_q.pop_front();
        if (ref_flip(int'(it.bp), int'(it.gp)))            tag = "R6";
        else if (it.gp[5:0] == 6'd0 && it.bp < 4'd4)        tag = "R5";
        else                                                tag = "R3";
        if (scan_bit !== it.b)
          $display("FAIL %s bit at pattern %0d pos %0d", tag, it.gp, it.bp);
        chk(scan_bit === it.b, tag, int'(scan_bit), int'(it.b));
        chk(pat_last === it.last, "R4", int'(pat_last), int'(it.last));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic do_run(input bit poke_mid, input string req);
    bit seen;
    push_run();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk);
    chk(scan_valid === 1'b1, "R2", int'(scan_valid), 1);
    #1 start = 1'b0;
    if (poke_mid) begin
      repeat (1300) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk);
      chk(scan_valid === 1'b1, "R8", int'(scan_valid), 1);
      #1 start = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, "R7 done", int'(seen), 1);
    chk(scan_valid === 1'b0, "R7 valid", int'(scan_valid), 0);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 pulse", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scan_valid === 1'b0 && pat_last === 1'b0 && done === 1'b0, "R1 in reset",
        int'({scan_valid, pat_last, done}), 0);
    #1 rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(scan_valid === 1'b0 && done === 1'b0, "R1 idle",
        int'({scan_valid, done}), 0);
    do_run(1'b1, "R9 stream complete");
    repeat (5) @(negedge clk);
    do_run(1'b0, "R10 rerun complete");
    summary();
  end
endmodule